// File: doc/BRIEF.md
# Power-Mode and System Clock Controller

This block manages the clocks of a small microcontroller. Running from a single high-speed oscillator clock `fH`, it produces a system-clock enable that fires either on every `fH` cycle or once every 2, 4, 8, 16, 32 or 64 cycles. A memory-mapped mode register chooses the ratio. Every output clock is a one-cycle enable pulse or a level enable, so downstream logic stays on the `fH` clock.

A halt request from the CPU moves the block from normal operation into one of three low-power states. The state is picked by two control bits: an idle-select bit in the mode register and a keep-oscillator bit in a separate control register. Each state has its own pattern of clock enables: the CPU, the system oscillator, the time-base clock, the sub clock and the slow clock.

A wake event returns the block to normal operation on the next edge. The CPU enable comes back only on a pulse of the divided clock.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode register reads 0x03 and the control register reads 0x00. The block is in normal mode and `cpu_clk_en_o` is high on every cycle.
- R2: With mode bit 0 (full-speed select) at 1, `sys_clk_en_o` is high on every `fH` cycle.
- R3: With full-speed select at 0, the code in mode bits 7:5 sets the period of `sys_clk_en_o`, which pulses once per N cycles: 3'b010 gives N=64, 3'b011 N=32, 3'b100 N=16, 3'b101 N=8, 3'b110 N=4, 3'b111 N=2.
- R4: A mode-register write whose bits 7:5 are 3'b000 or 3'b001 leaves the stored code unchanged but still updates bits 1 and 0. If the stored code is one of these (only possible after reset) and full-speed select is 0, N=64.
- R5: In the mode register, bit 4 always reads 0. Bit 3 reads `lo_rdy_i` and bit 2 reads `hi_rdy_i`, each registered one cycle and neither writable. The control register (`reg_sel_i`=1) holds only bit 0 (keep-oscillator); its other bits read 0.
- R6: A halt in normal mode with mode bit 1 (idle-select) at 0 enters sleep. In sleep the CPU enable, oscillator run, system-clock enable and time-base enable are 0, while the sub and slow enables stay 1.
- R7: A halt with idle-select 1 and keep-oscillator 0 enters idle0. In idle0 the CPU enable, oscillator run and system-clock enable are 0, while the time-base, sub and slow enables are 1.
- R8: A halt with idle-select 1 and keep-oscillator 1 enters idle1. In idle1 the oscillator runs and `sys_clk_en_o` keeps its divided rate, while the CPU enable is 0 and the time-base, sub and slow enables are 1.
- R9: A wake in any low-power state returns the block to normal mode on the next edge. The first CPU enable after a stopped oscillator comes N cycles after that edge.
- R10: A new ratio takes effect only after the divided-clock period in progress ends, so no period is shortened.
- R11: A halt is ignored outside normal mode, and a wake is ignored in normal mode.
- R12: In normal mode `cpu_clk_en_o` equals `sys_clk_en_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed oscillator clock fH |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects the mode register, 1 the control register |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| lo_rdy_i | input | 1 | Low oscillator ready flag |
| hi_rdy_i | input | 1 | High oscillator ready flag |
| halt_i | input | 1 | Halt request from the CPU |
| wake_i | input | 1 | Wake-up event |
| cpu_clk_en_o | output | 1 | CPU clock enable pulse |
| sys_osc_run_o | output | 1 | System oscillator run |
| sys_clk_en_o | output | 1 | Divided system-clock enable for peripherals |
| sub_clk_en_o | output | 1 | Sub clock enable |
| slow_clk_en_o | output | 1 | Slow clock enable |
| tb_clk_en_o | output | 1 | Time-base clock enable |

## Verification
The assertions check on every cycle that:
- a wake in a low-power state returns the block to normal mode;
- a halt outside normal mode leaves the state alone;
- a reserved code never changes the stored divide code;
- the divider keeps its ratio and counts by one in the middle of a period;
- the CPU enable matches the system-clock enable in normal mode.

Only the bench's scenarios can show the actual pulse rate for each divide code, the gating pattern of each low-power state, and the N-cycle delay to the first CPU pulse after a wake. They also show that a ratio written in mid-period lets the old period finish at its full length.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam int unsigned REG_W     = 8;
  localparam int unsigned MAX_SHIFT = 6;
  localparam int unsigned SHW       = $clog2(MAX_SHIFT + 1);

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_SLEEP = 2'd1,
    PM_IDLE0 = 2'd2,
    PM_IDLE1 = 2'd3
  } pm_state_t;

  typedef struct packed {
    logic cpu_gate;
    logic osc_run;
    logic tbase_on;
    logic sub_on;
    logic slow_on;
  } gate_set_t;

  // Clock gating pattern for each power state.
  function automatic gate_set_t gates_for(pm_state_t s);
    gate_set_t g;
    g.sub_on  = 1'b1;
    g.slow_on = 1'b1;
    case (s)
      PM_RUN:   begin g.cpu_gate = 1'b1; g.osc_run = 1'b1; g.tbase_on = 1'b1; end
      PM_SLEEP: begin g.cpu_gate = 1'b0; g.osc_run = 1'b0; g.tbase_on = 1'b0; end
      PM_IDLE0: begin g.cpu_gate = 1'b0; g.osc_run = 1'b0; g.tbase_on = 1'b1; end
      PM_IDLE1: begin g.cpu_gate = 1'b0; g.osc_run = 1'b1; g.tbase_on = 1'b1; end
      default:  begin g.cpu_gate = 1'b0; g.osc_run = 1'b0; g.tbase_on = 1'b0; end
    endcase
    return g;
  endfunction

  // Divide exponent: 0 at full speed, otherwise 8 - code.
  // A reserved code (0 or 1) gives the slowest ratio.
  function automatic logic [SHW-1:0] shift_for(logic full_speed, logic [2:0] code);
    logic [3:0] t;
    if (full_speed) begin
      t = 4'd0;
    end else if (code < 3'd2) begin
      t = 4'(MAX_SHIFT);
    end else begin
      t = 4'd8 - {1'b0, code};
    end
    return t[SHW-1:0];
  endfunction

endpackage

// File: rtl/pcc_regs.sv
module pcc_regs
  import pcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             lo_rdy_i,
  input  logic             hi_rdy_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [2:0]       div_code_o,
  output logic             full_speed_o,
  output logic             idle_sel_o,
  output logic             keep_osc_o
);

  logic [2:0] code_q, code_d;
  logic       full_q, full_d;
  logic       idle_q, idle_d;
  logic       keep_q, keep_d;
  logic       lo_q, hi_q;
  logic       unused_wr_bits;

  assign unused_wr_bits = ^{wdata_i[4:2]};

  always_comb begin
    code_d = code_q;
    full_d = full_q;
    idle_d = idle_q;
    keep_d = keep_q;
    if (wr_i && !sel_i) begin
      if (wdata_i[7:5] >= 3'd2) begin
        code_d = wdata_i[7:5];
      end
      idle_d = wdata_i[1];
      full_d = wdata_i[0];
    end
    if (wr_i && sel_i) begin
      keep_d = wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= 3'b000;
      full_q <= 1'b1;
      idle_q <= 1'b1;
      keep_q <= 1'b0;
      lo_q   <= 1'b0;
      hi_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      full_q <= full_d;
      idle_q <= idle_d;
      keep_q <= keep_d;
      lo_q   <= lo_rdy_i;
      hi_q   <= hi_rdy_i;
    end
  end

  always_comb begin
    if (sel_i) begin
      rdata_o = {{(REG_W-1){1'b0}}, keep_q};
    end else begin
      rdata_o = {code_q, 1'b0, lo_q, hi_q, idle_q, full_q};
    end
  end

  assign div_code_o   = code_q;
  assign full_speed_o = full_q;
  assign idle_sel_o   = idle_q;
  assign keep_osc_o   = keep_q;

  // R4: a reserved code never replaces the stored divide code
  p_rsvd_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !sel_i && (wdata_i[7:6] == 2'b00)) |=> $stable(code_q));

  // R5: a control-register write lands in the keep-oscillator bit
  p_ctrl_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i) |=> (keep_q == $past(wdata_i[0])));

endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      halt_i,
  input  logic      wake_i,
  input  logic      idle_sel_i,
  input  logic      keep_osc_i,
  output pm_state_t state_o
);

  pm_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PM_RUN: begin
        if (halt_i) begin
          if (!idle_sel_i)     state_d = PM_SLEEP;
          else if (keep_osc_i) state_d = PM_IDLE1;
          else                 state_d = PM_IDLE0;
        end
      end
      default: begin
        if (wake_i) state_d = PM_RUN;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PM_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R9: wake in a low-power state returns to normal on the next edge
  p_wake_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != PM_RUN) && wake_i) |=> (state_q == PM_RUN));

  // R11: without a wake, a low-power state holds even under a halt
  p_halt_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q != PM_RUN) && !wake_i) |=> $stable(state_q));

endmodule

// File: rtl/pcc_clk_div.sv
module pcc_clk_div
  import pcc_pkg::*;
#(
  parameter int unsigned CNT_W = MAX_SHIFT
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [SHW-1:0] shift_req_i,
  output logic           tick_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [SHW-1:0]   act_q, act_d;

  // Terminal count for the active ratio: 2**act - 1.
  assign lim    = ~({CNT_W{1'b1}} << act_q);
  assign tick_o = run_i && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!run_i) begin
      cnt_d = '0;
      act_d = shift_req_i;
    end else if (tick_o) begin
      cnt_d = '0;
      act_d = shift_req_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // R10: the ratio holds for the whole period in progress
  p_hold_ratio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> $stable(act_q));

  // R10: the counter steps by one mid-period, with no early restart
  p_count_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic       reg_sel_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       lo_rdy_i,
  input  logic       hi_rdy_i,
  input  logic       halt_i,
  input  logic       wake_i,
  output logic       cpu_clk_en_o,
  output logic       sys_osc_run_o,
  output logic       sys_clk_en_o,
  output logic       sub_clk_en_o,
  output logic       slow_clk_en_o,
  output logic       tb_clk_en_o
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[RST_STAGES-1];

  logic [2:0]     div_code;
  logic           full_speed, idle_sel, keep_osc;
  pm_state_t      state;
  gate_set_t      gates;
  logic [SHW-1:0] shift_req;
  logic           tick;

  pcc_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .wr_i         (reg_wr_i),
    .sel_i        (reg_sel_i),
    .wdata_i      (reg_wdata_i),
    .lo_rdy_i     (lo_rdy_i),
    .hi_rdy_i     (hi_rdy_i),
    .rdata_o      (reg_rdata_o),
    .div_code_o   (div_code),
    .full_speed_o (full_speed),
    .idle_sel_o   (idle_sel),
    .keep_osc_o   (keep_osc)
  );

  pcc_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .halt_i     (halt_i),
    .wake_i     (wake_i),
    .idle_sel_i (idle_sel),
    .keep_osc_i (keep_osc),
    .state_o    (state)
  );

  assign gates     = gates_for(state);
  assign shift_req = shift_for(full_speed, div_code);

  pcc_clk_div #(.CNT_W(MAX_SHIFT)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (gates.osc_run),
    .shift_req_i (shift_req),
    .tick_o      (tick)
  );

  assign sys_osc_run_o = gates.osc_run;
  assign sys_clk_en_o  = tick;
  assign cpu_clk_en_o  = tick && gates.cpu_gate;
  assign tb_clk_en_o   = gates.tbase_on;
  assign sub_clk_en_o  = gates.sub_on;
  assign slow_clk_en_o = gates.slow_on;

  // R12: in normal mode the CPU sees every divided pulse
  p_run_cpu_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PM_RUN) |-> (cpu_clk_en_o == sys_clk_en_o));

  // R6: sleep stops the oscillator and the time base
  p_sleep_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PM_SLEEP) |-> (!sys_osc_run_o && !sys_clk_en_o && !tb_clk_en_o));

  // R8: idle1 keeps peripherals clocked but never the CPU
  p_idle1_no_cpu_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PM_IDLE1) |-> (sys_osc_run_o && !cpu_clk_en_o));

endmodule

// File: tb/tb_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_clk_ctrl;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       reg_wr_i, reg_sel_i;
  logic [7:0] reg_wdata_i, reg_rdata_o;
  logic       lo_rdy_i, hi_rdy_i, halt_i, wake_i;
  logic       cpu_clk_en_o, sys_osc_run_o, sys_clk_en_o;
  logic       sub_clk_en_o, slow_clk_en_o, tb_clk_en_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  pwr_clk_ctrl dut (.*);

  // {write byte, pulses in 128 cycles, readback}
  localparam logic [23:0] VEC [10] = '{
    {8'h03, 8'd128, 8'h03},
    {8'h42, 8'd2,   8'h42},
    {8'h62, 8'd4,   8'h62},
    {8'h82, 8'd8,   8'h82},
    {8'hA2, 8'd16,  8'hA2},
    {8'hC2, 8'd32,  8'hC2},
    {8'hE2, 8'd64,  8'hE2},
    {8'h02, 8'd64,  8'hE2},
    {8'h22, 8'd64,  8'hE2},
    {8'h5E, 8'd2,   8'h42}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    reg_sel_i = sel;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse_halt();
    halt_i = 1'b1;
    @(negedge clk_i);
    halt_i = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_i = 1'b1;
    @(negedge clk_i);
    wake_i = 1'b0;
  endtask

  task automatic count(input int n, output int sys_n, output int cpu_n, output int mism);
    sys_n = 0; cpu_n = 0; mism = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (sys_clk_en_o) sys_n++;
      if (cpu_clk_en_o) cpu_n++;
      if (sys_clk_en_o != cpu_clk_en_o) mism++;
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(3);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int s, c, m, k;
    reg_wr_i = 0; reg_sel_i = 0; reg_wdata_i = 0;
    lo_rdy_i = 0; hi_rdy_i = 0; halt_i = 0; wake_i = 0;
    @(negedge clk_i);
    do_reset();

    // R1 reset state
    rd_reg(1'b0, rd); chk("R1 mode reg", rd, 8'h03);
    rd_reg(1'b1, rd); chk("R1 ctrl reg", rd, 8'h00);
    reg_sel_i = 1'b0;
    count(16, s, c, m);
    chk("R1 cpu every cycle", c, 16);

    // R2 R3 R4 R5 ratio table
    foreach (VEC[i]) begin
      wr_reg(1'b0, VEC[i][23:16]);
      wait_cyc(70);
      count(128, s, c, m);
      chk($sformatf("R3 ratio vector %0d", i), s, int'(VEC[i][15:8]));
      chk($sformatf("R12 cpu matches sys vector %0d", i), m, 0);
      rd_reg(1'b0, rd);
      chk($sformatf("R4 R5 readback vector %0d", i), rd, int'(VEC[i][7:0]));
    end

    // R5 ready flags
    lo_rdy_i = 1'b1; wait_cyc(2);
    rd_reg(1'b0, rd); chk("R5 lo ready bit3", rd[3], 1); chk("R5 hi ready bit2", rd[2], 0);
    hi_rdy_i = 1'b1; lo_rdy_i = 1'b0; wait_cyc(2);
    rd_reg(1'b0, rd); chk("R5 hi ready bit2 set", rd[2], 1); chk("R5 lo ready bit3 clr", rd[3], 0);
    hi_rdy_i = 1'b0;
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, rd); chk("R5 ctrl only bit0", rd, 8'h01);
    wr_reg(1'b1, 8'h00);

    // R10 ratio change mid-period: /64 then /2
    wr_reg(1'b0, 8'h42);
    wait_cyc(70);
    k = 0;
    while (!sys_clk_en_o && k < 200) begin @(negedge clk_i); k++; end
    wr_reg(1'b0, 8'hE2);
    k = 1;
    while (!sys_clk_en_o && k < 200) begin @(negedge clk_i); k++; end
    chk("R10 old period completes", k, 64);
    @(negedge clk_i); k = 1;
    while (!sys_clk_en_o && k < 200) begin @(negedge clk_i); k++; end
    chk("R10 new period applied", k, 2);

    // R6 sleep, N=4
    wr_reg(1'b0, 8'hC0);
    wait_cyc(70);
    pulse_halt();
    chk("R6 sleep osc", sys_osc_run_o, 0);
    chk("R6 sleep tb", tb_clk_en_o, 0);
    chk("R6 sleep sub", sub_clk_en_o, 1);
    chk("R6 sleep slow", slow_clk_en_o, 1);
    count(32, s, c, m);
    chk("R6 sleep no sys", s, 0);
    chk("R6 sleep no cpu", c, 0);

    // R11 halt ignored in sleep
    wr_reg(1'b0, 8'hC2);
    wr_reg(1'b1, 8'h01);
    pulse_halt();
    chk("R11 halt ignored osc", sys_osc_run_o, 0);
    chk("R11 halt ignored tb", tb_clk_en_o, 0);

    // R9 wake from sleep
    pulse_wake();
    chk("R9 wake normal osc", sys_osc_run_o, 1);
    k = 1;
    while (!cpu_clk_en_o && k < 200) begin @(negedge clk_i); k++; end
    chk("R9 first cpu after N", k, 4);

    // R7 idle0
    wr_reg(1'b1, 8'h00);
    pulse_halt();
    chk("R7 idle0 osc", sys_osc_run_o, 0);
    chk("R7 idle0 tb", tb_clk_en_o, 1);
    chk("R7 idle0 sub", sub_clk_en_o, 1);
    chk("R7 idle0 slow", slow_clk_en_o, 1);
    count(32, s, c, m);
    chk("R7 idle0 no sys", s, 0);
    chk("R7 idle0 no cpu", c, 0);
    pulse_wake();
    chk("R9 wake idle0 osc", sys_osc_run_o, 1);
    k = 1;
    while (!cpu_clk_en_o && k < 200) begin @(negedge clk_i); k++; end
    chk("R9 idle0 first cpu after N", k, 4);

    // R8 idle1
    wr_reg(1'b1, 8'h01);
    pulse_halt();
    chk("R8 idle1 osc", sys_osc_run_o, 1);
    chk("R8 idle1 tb", tb_clk_en_o, 1);
    count(64, s, c, m);
    chk("R8 idle1 sys rate", s, 16);
    chk("R8 idle1 no cpu", c, 0);
    pulse_wake();
    count(64, s, c, m);
    chk("R9 idle1 cpu resumes", c, 16);

    // R11 wake ignored in normal
    pulse_wake();
    chk("R11 wake in normal osc", sys_osc_run_o, 1);
    count(64, s, c, m);
    chk("R11 wake in normal cpu rate", c, 16);
    chk("R12 cpu equals sys", m, 0);

    // R4 reserved stored code after reset gives /64
    do_reset();
    wr_reg(1'b0, 8'h02);
    rd_reg(1'b0, rd); chk("R4 reserved code kept", rd, 8'h02);
    wait_cyc(70);
    count(128, s, c, m);
    chk("R4 reserved stored gives /64", s, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule